// File: doc/BRIEF.md
# Channel-Zero Message Extraction Unit

This unit watches the first time slot (slot 0) of every frame on each input line of a switching matrix and decides which of those slot-0 bytes are real messages for the processor. A line-select mask, written by the processor, names the lines to watch. The mask is kept in two places: a background copy that never changes until the next write, and a working "expected" copy that is refreshed from the background copy at every frame start. When the slot-0 bytes arrive, the working copy keeps only the selected lines whose byte does not start with the idle label `01`.

When at least one message remains, the unit loads the message count into the count register, drops its active-low status output for two clock cycles, and lets the processor fetch the captured bytes one by one, lowest line first. A report waits while short commands are still in progress and while the previous count has not been read. A zero count produces no report. Writing an all-zero mask stops the per-frame cycle.

Top module: `cz_extract_top`

## Requirements
- R1: After a synchronous reset, `status_n` is 1, `or2_count` is 0, `data_out` is 0 and `active` is 0.
- R2: A mask write with a non-zero value sets `active` to 1 in the next cycle. A mask write of all zeros clears `active`, and later frame starts and slot-0 bytes then produce no report.
- R3: Line i's slot-0 byte sits in `slot0_bytes[i*BYTE_W +: BYTE_W]`, and its bit BYTE_W-1 is the first serial bit. A byte on a selected line counts as a message unless its two top bits are `01`. Bytes on lines whose mask bit is 0 never count.
- R4: A report happens only when the count is non-zero. On a report, `or2_count` takes the count, and `status_n` goes low in the cycle after the report is allowed and stays low for exactly two cycles.
- R5: Every `frame_start` copies the background mask back into the expected register. A line dropped in one frame for carrying `01` counts again in a later frame if its byte is then a message.
- R6: While `short_busy` is 1, a pending report is held back: `status_n` stays 1 and `or2_count` keeps its old value. The report follows once `short_busy` returns to 0.
- R7: A report is held back while the previous count has not been read with `or2_rd`. After that read, the held report goes out.
- R8: After a report, each `data_rd` returns in `data_out` the captured byte of the lowest line still set in the expected register, then clears that bit. When no line is left, a read returns 0x00.
- R9: A `slot0_valid` pulse that comes while no frame is open (no `frame_start` since the last collection) is ignored and causes no report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| slot0_valid | input | 1 | One-cycle pulse when the slot-0 bytes of all lines are present |
| slot0_bytes | input | NUM_LINES*BYTE_W | Slot-0 byte of each line; line i in bits [i*BYTE_W +: BYTE_W] |
| mask_wr | input | 1 | Write strobe for the line-select mask |
| mask_in | input | NUM_LINES | Mask value; bit i selects line i |
| short_busy | input | 1 | High while short commands are still pending |
| or2_rd | input | 1 | Read strobe for the count register; marks it as read |
| data_rd | input | 1 | Fetch strobe for the next captured byte |
| or2_count | output | CNT_W | Number of messages from the latest report |
| data_out | output | BYTE_W | Byte returned by the latest fetch |
| status_n | output | 1 | Active-low report pulse, two cycles long |
| active | output | 1 | High while a non-zero mask is armed |

## Verification
Slot-0 patterns mix message bytes, `01`-labelled bytes and bytes on unselected lines in one frame. This shows that the label filter and the mask act on separate lines, and that bytes with a `00` prefix are still counted. A later frame flips which lines carry labels, which separates a true per-frame reload from a mask that only shrinks. An all-label frame, a stray `slot0_valid` outside a frame and a zeroed mask each must stay silent, while held-back reports under `short_busy` and under an unread count must come out late but with the right count and the fetch order must run from the lowest line upward.

// File: rtl/cz_pkg.sv
package cz_pkg;
  typedef enum logic [2:0] {
    CZ_IDLE    = 3'd0,
    CZ_WAIT    = 3'd1,
    CZ_COLLECT = 3'd2,
    CZ_PEND    = 3'd3,
    CZ_REPORT  = 3'd4
  } cz_state_t;
endpackage

// File: rtl/cz_msg_filter.sv
module cz_msg_filter #(
  parameter int NUM_LINES = 8,
  parameter int BYTE_W    = 8,
  parameter int CNT_W     = 4
) (
  input  logic [NUM_LINES*BYTE_W-1:0] bytes_in,
  input  logic [NUM_LINES-1:0]        sel,
  output logic [NUM_LINES-1:0]        keep,
  output logic [CNT_W-1:0]            count
);
  // a byte whose two leading bits read 01 carries the idle label
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic [1:0] lead;
    assign lead    = bytes_in[g*BYTE_W + BYTE_W - 1 -: 2];
    assign keep[g] = sel[g] && (lead != 2'b01);
  end

  always_comb begin
    count = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      count = count + {{(CNT_W-1){1'b0}}, keep[i]};
    end
  end
endmodule

// File: rtl/cz_line_pick.sv
module cz_line_pick #(
  parameter int NUM_LINES = 8,
  parameter int IDX_W     = 3
) (
  input  logic [NUM_LINES-1:0] req,
  output logic                 found,
  output logic [IDX_W-1:0]     idx
);
  // scan downward so the lowest set line is the last to win
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/cz_slot_store.sv
module cz_slot_store #(
  parameter int NUM_LINES = 8,
  parameter int BYTE_W    = 8,
  parameter int IDX_W     = 3
) (
  input  logic                        clk,
  input  logic                        wr_en,
  input  logic [NUM_LINES-1:0]        wr_sel,
  input  logic [NUM_LINES*BYTE_W-1:0] wr_bytes,
  input  logic [IDX_W-1:0]            rd_idx,
  output logic [BYTE_W-1:0]           rd_byte
);
  logic [BYTE_W-1:0] slot_mem [NUM_LINES];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (wr_en && wr_sel[g]) slot_mem[g] <= wr_bytes[g*BYTE_W +: BYTE_W];
    end
  end

  assign rd_byte = slot_mem[rd_idx];
endmodule

// File: rtl/cz_extract_top.sv
module cz_extract_top
  import cz_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int BYTE_W    = 8,
  localparam int CNT_W    = $clog2(NUM_LINES + 1),
  localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        frame_start,
  input  logic                        slot0_valid,
  input  logic [NUM_LINES*BYTE_W-1:0] slot0_bytes,
  input  logic                        mask_wr,
  input  logic [NUM_LINES-1:0]        mask_in,
  input  logic                        short_busy,
  input  logic                        or2_rd,
  input  logic                        data_rd,
  output logic [CNT_W-1:0]            or2_count,
  output logic [BYTE_W-1:0]           data_out,
  output logic                        status_n,
  output logic                        active
);
  cz_state_t             state_q;
  logic [NUM_LINES-1:0]  bg_q;
  logic [NUM_LINES-1:0]  exp_q;
  logic [CNT_W-1:0]      cnt_q;
  logic [CNT_W-1:0]      or2_q;
  logic                  unread_q;
  logic [BYTE_W-1:0]     data_q;
  logic                  stat_n_q;
  logic                  hold_q;

  logic [NUM_LINES-1:0]  keep;
  logic [CNT_W-1:0]      msg_cnt;
  logic                  pick_found;
  logic [IDX_W-1:0]      pick_idx;
  logic [BYTE_W-1:0]     pick_byte;
  logic                  ctrl_free;
  logic                  capture;
  logic                  start_rpt;
  logic                  rpt_phase;

  assign ctrl_free = !mask_wr && !(frame_start && state_q != CZ_IDLE);
  assign capture   = ctrl_free && state_q == CZ_COLLECT && slot0_valid;
  assign start_rpt = ctrl_free && state_q == CZ_PEND && !short_busy && !unread_q;
  assign rpt_phase = (state_q == CZ_REPORT);

  cz_msg_filter #(.NUM_LINES(NUM_LINES), .BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_filter (
    .bytes_in (slot0_bytes),
    .sel      (exp_q),
    .keep     (keep),
    .count    (msg_cnt)
  );

  cz_line_pick #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_pick (
    .req   (exp_q),
    .found (pick_found),
    .idx   (pick_idx)
  );

  cz_slot_store #(.NUM_LINES(NUM_LINES), .BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_store (
    .clk      (clk),
    .wr_en    (capture),
    .wr_sel   (keep),
    .wr_bytes (slot0_bytes),
    .rd_idx   (pick_idx),
    .rd_byte  (pick_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= CZ_IDLE;
      bg_q     <= '0;
      exp_q    <= '0;
      cnt_q    <= '0;
      or2_q    <= '0;
      unread_q <= 1'b0;
      data_q   <= '0;
      stat_n_q <= 1'b1;
      hold_q   <= 1'b0;
    end else begin
      hold_q   <= start_rpt;
      stat_n_q <= !(start_rpt || hold_q);
      if (or2_rd) unread_q <= 1'b0;

      if (mask_wr) begin
        bg_q    <= mask_in;
        exp_q   <= mask_in;
        state_q <= (mask_in != '0) ? CZ_WAIT : CZ_IDLE;
      end else if (frame_start && state_q != CZ_IDLE) begin
        exp_q   <= bg_q;
        state_q <= CZ_COLLECT;
      end else begin
        unique case (state_q)
          CZ_COLLECT: begin
            if (slot0_valid) begin
              exp_q   <= keep;
              cnt_q   <= msg_cnt;
              state_q <= (msg_cnt != '0) ? CZ_PEND : CZ_WAIT;
            end
          end
          CZ_PEND: begin
            if (start_rpt) begin
              or2_q    <= cnt_q;
              unread_q <= 1'b1;
              state_q  <= CZ_REPORT;
            end
          end
          CZ_REPORT: begin
            if (data_rd) begin
              if (pick_found) begin
                data_q          <= pick_byte;
                exp_q[pick_idx] <= 1'b0;
              end else begin
                data_q <= '0;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign or2_count = or2_q;
  assign data_out  = data_q;
  assign status_n  = stat_n_q;
  assign active    = (state_q != CZ_IDLE);
endmodule

// File: rtl/cz_extract_checker.sv
module cz_extract_checker #(
  parameter int NUM_LINES = 8,
  parameter int CNT_W     = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 status_n,
  input logic [CNT_W-1:0]     or2_count,
  input logic                 short_busy,
  input logic                 mask_wr,
  input logic [NUM_LINES-1:0] mask_in,
  input logic                 active,
  input logic                 data_rd,
  input logic                 frame_start,
  input logic [NUM_LINES-1:0] exp_mask,
  input logic                 rpt_phase
);
  assert_arm_R2: assert property (@(posedge clk) disable iff (rst)
    (mask_wr && mask_in != '0) |=> active);

  assert_disarm_R2: assert property (@(posedge clk) disable iff (rst)
    (mask_wr && mask_in == '0) |=> !active);

  assert_report_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(status_n) |-> (or2_count != '0));

  assert_pulse_second_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(status_n) |=> !status_n);

  assert_pulse_end_R4: assert property (@(posedge clk) disable iff (rst)
    (!status_n && !$past(status_n)) |=> status_n);

  assert_count_only_on_report_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(or2_count) |-> $fell(status_n));

  assert_busy_holds_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(status_n) |-> !$past(short_busy));

  assert_fetch_clears_one_R8: assert property (@(posedge clk) disable iff (rst)
    (data_rd && rpt_phase && exp_mask != '0 && !mask_wr && !frame_start)
      |=> ($countones(exp_mask) == $countones($past(exp_mask)) - 1));
endmodule

bind cz_extract_top cz_extract_checker #(.NUM_LINES(NUM_LINES), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .status_n    (status_n),
  .or2_count   (or2_count),
  .short_busy  (short_busy),
  .mask_wr     (mask_wr),
  .mask_in     (mask_in),
  .active      (active),
  .data_rd     (data_rd),
  .frame_start (frame_start),
  .exp_mask    (exp_q),
  .rpt_phase   (rpt_phase)
);

// File: tb/cz_extract_top_tb.sv
module cz_extract_top_tb;
  localparam int N  = 8;
  localparam int BW = 8;
  localparam int CW = $clog2(N + 1);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            frame_start = 1'b0;
  logic            slot0_valid = 1'b0;
  logic [N*BW-1:0] slot0_bytes = '0;
  logic            mask_wr = 1'b0;
  logic [N-1:0]    mask_in = '0;
  logic            short_busy = 1'b0;
  logic            or2_rd = 1'b0;
  logic            data_rd = 1'b0;
  logic [CW-1:0]   or2_count;
  logic [BW-1:0]   data_out;
  logic            status_n;
  logic            active;

  int n_checks = 0;
  int n_fail   = 0;
  logic [N-1:0] model_mask = '0;
  int exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  cz_extract_top #(.NUM_LINES(N), .BYTE_W(BW)) u_dut (
    .clk(clk), .rst(rst), .frame_start(frame_start), .slot0_valid(slot0_valid),
    .slot0_bytes(slot0_bytes), .mask_wr(mask_wr), .mask_in(mask_in),
    .short_busy(short_busy), .or2_rd(or2_rd), .data_rd(data_rd),
    .or2_count(or2_count), .data_out(data_out), .status_n(status_n), .active(active)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  function automatic int model_count(input logic [N-1:0] m, input logic [N*BW-1:0] b);
    int c = 0;
    for (int i = 0; i < N; i++)
      if (m[i] && b[i*BW + BW - 1 -: 2] != 2'b01) c++;
    return c;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_mask(input logic [N-1:0] m);
    @(negedge clk); mask_wr = 1'b1; mask_in = m;
    @(negedge clk); mask_wr = 1'b0;
    model_mask = m;
  endtask

  // driver: plays one frame and pushes the report it should produce
  task automatic play_frame(input logic [N*BW-1:0] b, input string req);
    int c;
    c = (model_mask != '0) ? model_count(model_mask, b) : 0;
    if (c != 0) begin exp_q.push_back(c); tag_q.push_back(req); end
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0; slot0_bytes = b; slot0_valid = 1'b1;
    @(negedge clk); slot0_valid = 1'b0;
  endtask

  task automatic pulse_or2_rd();
    @(negedge clk); or2_rd = 1'b1;
    @(negedge clk); or2_rd = 1'b0;
  endtask

  task automatic fetch(input logic [BW-1:0] expv, input string req);
    @(negedge clk); data_rd = 1'b1;
    @(negedge clk); data_rd = 1'b0;
    check(data_out == expv, req, data_out, expv);
  endtask

  task automatic expect_quiet(input int n, input string req);
    bit low = 1'b0;
    repeat (n) begin @(negedge clk); if (!status_n) low = 1'b1; end
    check(!low, req, int'(low), 0);
  endtask

  // monitor: pops expected reports as status_n falls, checks pulse width
  bit prev_n = 1'b1;
  int low_len = 0;
  always @(negedge clk) begin
    if (rst) begin
      prev_n  = 1'b1;
      low_len = 0;
    end else begin
      if (prev_n && !status_n) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2/R4 unexpected report", or2_count, 0);
        end else begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(or2_count == CW'(e), t, or2_count, e);
        end
      end
      if (!status_n) low_len++;
      else if (!prev_n) begin
        check(low_len == 2, "R4 pulse width", low_len, 2);
        low_len = 0;
      end
      prev_n = status_n;
    end
  end

  initial begin
    #(5 * 100000);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  function automatic logic [N*BW-1:0] pack(input logic [BW-1:0] b [N]);
    logic [N*BW-1:0] r;
    for (int i = 0; i < N; i++) r[i*BW +: BW] = b[i];
    return r;
  endfunction

  initial begin
    logic [BW-1:0] bt [N];
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(status_n == 1'b1, "R1 status_n", status_n, 1);
    check(or2_count == '0, "R1 or2_count", or2_count, 0);
    check(data_out == '0, "R1 data_out", data_out, 0);
    check(active == 1'b0, "R1 active", active, 0);

    // R2 arm, R3 filter, R4 report, R8 fetch order
    write_mask(8'b1011_0101);
    check(active == 1'b1, "R2 arm", active, 1);
    bt = '{8'h80, 8'h99, 8'h41, 8'hAA, 8'h3C, 8'hC3, 8'hAA, 8'h7F};
    play_frame(pack(bt), "R3 count mixed frame");
    idle(4);
    fetch(8'h80, "R8 first line0");
    fetch(8'h3C, "R8 second line4");
    fetch(8'hC3, "R8 third line5");
    fetch(8'h00, "R8 exhausted");
    pulse_or2_rd();

    // R5 reload brings back dropped lines
    bt = '{8'h41, 8'h99, 8'h90, 8'hAA, 8'h12, 8'hFF, 8'hAA, 8'h01};
    play_frame(pack(bt), "R5 reload count");
    idle(4);
    fetch(8'h90, "R5 line2 back");
    fetch(8'h12, "R8 line4");
    fetch(8'hFF, "R8 line5");
    fetch(8'h01, "R5 line7 back");
    pulse_or2_rd();

    // R4 zero count: every selected line labelled
    bt = '{8'h40, 8'h80, 8'h40, 8'h80, 8'h40, 8'h40, 8'h80, 8'h40};
    play_frame(pack(bt), "R4 zero");
    expect_quiet(6, "R4 no report on zero count");

    // R9 slot-0 bytes with no open frame
    @(negedge clk); slot0_bytes = {N{8'h80}}; slot0_valid = 1'b1;
    @(negedge clk); slot0_valid = 1'b0;
    expect_quiet(6, "R9 stray slot0 ignored");

    // R6 held back by short commands
    short_busy = 1'b1;
    play_frame({N{8'h80}}, "R6 late report");
    expect_quiet(8, "R6 quiet while busy");
    check(or2_count == CW'(4), "R6 count unchanged", or2_count, 4);
    short_busy = 1'b0;
    idle(4);

    // R7 held back until count read
    bt = '{8'h80, 8'h40, 8'h40, 8'h40, 8'h40, 8'h40, 8'h40, 8'h40};
    play_frame(pack(bt), "R7 late report");
    expect_quiet(8, "R7 quiet while unread");
    pulse_or2_rd();
    idle(4);
    fetch(8'h80, "R7 fetch line0");
    fetch(8'h00, "R8 exhausted again");
    pulse_or2_rd();

    // R2 zero mask disarms
    write_mask('0);
    check(active == 1'b0, "R2 disarm", active, 0);
    play_frame({N{8'h80}}, "R2 none");
    expect_quiet(6, "R2 no report when disarmed");

    idle(4);
    check(exp_q.size() == 0, "R4 all reports seen", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule